// File: doc/BRIEF.md
# Banked Dual-Read Single-Write Data Array

This block is a storage array that behaves as if it had three ports: two independent read ports and one write port, all serviced in the same clock cycle. It holds 256 words of 32 bits, split into 16 banks of 16 words. Each read port names one word with an 8-bit address. The write port names an aligned pair of adjacent words with a 7-bit address and carries 64 bits of data, with one enable per 32-bit half.

Addresses are decoded in two stages: a bank select from the upper bits, then a row inside the bank from the lower bits. A collision stage compares each read's bank with the bank being written. A read that lands in the written bank is not served. Its port reports a blocked flag instead of a valid flag, so the write always takes priority. Reads on the two ports never interfere with each other, even when they target the same word.

Requests are captured at a clock edge and their results appear on registered outputs in the following cycle. The surrounding pipeline uses the blocked flag to replay the read.

Top module: `tri_port_bank_array`

## Requirements
- R1: Read address bits [7:4] select one of 16 banks and bits [3:0] select one of 16 words in it. A read issued with its enable high at a clock edge returns that word on its data output, with valid high, during the next cycle.
- R2: The two read ports are independent. Both return correct data in the same cycle when they address different banks, the same bank, or the very same word.
- R3: Write address bits [6:3] select the bank and bits [2:0] select a word pair. Write data bits [31:0] go to the even word (read address {bank, pair, 0}) and bits [63:32] go to the odd word (read address {bank, pair, 1}).
- R4: Half-enable bit 0 gates the even word and bit 1 gates the odd word. A word whose enable bit is low keeps its previous contents.
- R5: A write is active when write enable is high and at least one half-enable bit is set. If an enabled read addresses the bank of an active write at the same edge, that port shows blocked=1 and valid=0 in the next cycle, and the word is not returned. This applies to either port or both.
- R6: A write with enable high but both half-enable bits low, or with enable low, blocks no read and changes no word. A read to another bank in the same cycle as an active write returns its stored word.
- R7: While a port's valid output is low, its data output holds the value of that port's last valid read.
- R8: A synchronous active-high reset forces valid and blocked low on both ports in the cycle after the reset edge. The array contents are not cleared by reset.
- R9: A port whose enable was low at an edge shows valid=0 and blocked=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd0_en | input | 1 | Read port 0 request |
| rd0_addr | input | 8 | Read port 0 word address |
| rd1_en | input | 1 | Read port 1 request |
| rd1_addr | input | 8 | Read port 1 word address |
| wr_en | input | 1 | Write request |
| wr_half | input | 2 | Per-word write enables (bit 0 even, bit 1 odd) |
| wr_addr | input | 7 | Write word-pair address |
| wr_data | input | 64 | Write data: [31:0] even word, [63:32] odd word |
| rd0_data | output | 32 | Read port 0 result |
| rd0_valid | output | 1 | Read port 0 result is valid |
| rd0_blocked | output | 1 | Read port 0 was suppressed by a write collision |
| rd1_data | output | 32 | Read port 1 result |
| rd1_valid | output | 1 | Read port 1 result is valid |
| rd1_blocked | output | 1 | Read port 1 was suppressed by a write collision |

## Verification
A wrong bank or row decode, or a swapped write half, appears one cycle after the read that touches the damaged word, as a data mismatch. It may surface much later if that word is read only after other traffic. A faulty collision compare appears as a wrong valid/blocked pair in the cycle right after the colliding request. A leaking half-enable or a write that proceeds with both halves disabled shows up only on a later read-back of the neighbouring word. A data register that updates on a blocked or idle cycle is caught by the hold check on the next idle or blocked result.

// File: rtl/tpba_pkg.sv
package tpba_pkg;
  // Number of read ports served per cycle.
  localparam int NUM_RD = 2;
  // Number of words written by one write request (even/odd pair).
  localparam int WR_WORDS = 2;
endpackage

// File: rtl/tpba_decode.sv
module tpba_decode
  import tpba_pkg::*;
#(
  parameter int N_BANKS    = 16,
  parameter int BANK_DEPTH = 16
) (
  input  logic [NUM_RD-1:0][$clog2(N_BANKS)+$clog2(BANK_DEPTH)-1:0] rd_addr,
  input  logic                                                      wr_act,
  input  logic [$clog2(N_BANKS)+$clog2(BANK_DEPTH)-2:0]             wr_addr,
  output logic [NUM_RD-1:0][$clog2(N_BANKS)-1:0]                    rd_bank,
  output logic [NUM_RD-1:0][$clog2(BANK_DEPTH)-1:0]                 rd_row,
  output logic [NUM_RD-1:0][N_BANKS-1:0]                            rd_bank_oh,
  output logic [N_BANKS-1:0]                                        wr_bank_oh,
  output logic [$clog2(BANK_DEPTH)-2:0]                             wr_pair
);
  localparam int BANK_W = $clog2(N_BANKS);
  localparam int ROW_W  = $clog2(BANK_DEPTH);
  localparam int PAIR_W = ROW_W - 1;

  logic [BANK_W-1:0] wr_bank;

  // First stage: bank field; second stage: row inside the bank.
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      rd_bank[p] = rd_addr[p][ROW_W +: BANK_W];
      rd_row[p]  = rd_addr[p][ROW_W-1:0];
      for (int b = 0; b < N_BANKS; b++) begin
        rd_bank_oh[p][b] = (rd_addr[p][ROW_W +: BANK_W] == BANK_W'(b));
      end
    end
  end

  assign wr_bank = wr_addr[PAIR_W +: BANK_W];
  assign wr_pair = wr_addr[PAIR_W-1:0];

  always_comb begin
    for (int b = 0; b < N_BANKS; b++) begin
      wr_bank_oh[b] = wr_act && (wr_bank == BANK_W'(b));
    end
  end
endmodule

// File: rtl/tpba_collide.sv
module tpba_collide
  import tpba_pkg::*;
#(
  parameter int N_BANKS = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_RD-1:0]              rd_en,
  input  logic [NUM_RD-1:0][N_BANKS-1:0] rd_bank_oh,
  input  logic [N_BANKS-1:0]             wr_bank_oh,
  output logic [NUM_RD-1:0]              rd_block,
  output logic [NUM_RD-1:0]              rd_go
);
  // A write claims its whole bank; any read into it is suppressed.
  always_comb begin
    for (int p = 0; p < NUM_RD; p++) begin
      rd_block[p] = rd_en[p] && |(rd_bank_oh[p] & wr_bank_oh);
      rd_go[p]    = rd_en[p] && !rd_block[p] && !rst;
    end
  end

  AST_WR_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_bank_oh)); // R3

  AST_RD_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_bank_oh[0]) == 1 && $countones(rd_bank_oh[1]) == 1); // R1
endmodule

// File: rtl/tpba_bank.sv
module tpba_bank
  import tpba_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BANK_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [WR_WORDS-1:0]               wr_we,
  input  logic [$clog2(BANK_DEPTH)-2:0]     wr_pair,
  input  logic [WR_WORDS*DATA_W-1:0]        wr_data,
  input  logic [NUM_RD-1:0]                 rd_go,
  input  logic [NUM_RD-1:0][$clog2(BANK_DEPTH)-1:0] rd_row,
  output logic [NUM_RD-1:0][DATA_W-1:0]     rd_q
);
  localparam int ROW_W    = $clog2(BANK_DEPTH);
  localparam int PAIR_W   = ROW_W - 1;
  localparam int HALF_DEP = BANK_DEPTH / WR_WORDS;

  // Even and odd words live in separate memories so each has one write port.
  logic [DATA_W-1:0] mem_even [HALF_DEP];
  logic [DATA_W-1:0] mem_odd  [HALF_DEP];

  always_ff @(posedge clk) begin
    if (!rst && wr_we[0]) mem_even[wr_pair] <= wr_data[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst && wr_we[1]) mem_odd[wr_pair] <= wr_data[2*DATA_W-1:DATA_W];
  end

  // Read-first registered read per port; register holds when not read.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [PAIR_W-1:0] idx;
    assign idx = rd_row[p][ROW_W-1:1];
    always_ff @(posedge clk) begin
      if (rd_go[p]) begin
        rd_q[p] <= rd_row[p][0] ? mem_odd[idx] : mem_even[idx];
      end
    end
  end

  AST_NO_RD_IN_WR_BANK: assert property (@(posedge clk) disable iff (rst)
    (|wr_we) |-> (rd_go == '0)); // R5
endmodule

// File: rtl/tri_port_bank_array.sv
module tri_port_bank_array
  import tpba_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int N_BANKS    = 16,
  parameter int BANK_DEPTH = 16
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              rd0_en,
  input  logic [$clog2(N_BANKS)+$clog2(BANK_DEPTH)-1:0]     rd0_addr,
  input  logic                                              rd1_en,
  input  logic [$clog2(N_BANKS)+$clog2(BANK_DEPTH)-1:0]     rd1_addr,
  input  logic                                              wr_en,
  input  logic [1:0]                                        wr_half,
  input  logic [$clog2(N_BANKS)+$clog2(BANK_DEPTH)-2:0]     wr_addr,
  input  logic [2*DATA_W-1:0]                               wr_data,
  output logic [DATA_W-1:0]                                 rd0_data,
  output logic                                              rd0_valid,
  output logic                                              rd0_blocked,
  output logic [DATA_W-1:0]                                 rd1_data,
  output logic                                              rd1_valid,
  output logic                                              rd1_blocked
);
  localparam int BANK_W = $clog2(N_BANKS);
  localparam int ROW_W  = $clog2(BANK_DEPTH);
  localparam int RD_AW  = BANK_W + ROW_W;
  localparam int PAIR_W = ROW_W - 1;

  logic                                  wr_act;
  logic [NUM_RD-1:0]                     port_en;
  logic [NUM_RD-1:0][RD_AW-1:0]          port_addr;
  logic [NUM_RD-1:0][BANK_W-1:0]         port_bank;
  logic [NUM_RD-1:0][ROW_W-1:0]          port_row;
  logic [NUM_RD-1:0][N_BANKS-1:0]        port_bank_oh;
  logic [N_BANKS-1:0]                    wr_bank_oh;
  logic [PAIR_W-1:0]                     wr_pair;
  logic [NUM_RD-1:0]                     port_block;
  logic [NUM_RD-1:0]                     port_go;
  logic [N_BANKS-1:0][NUM_RD-1:0]        bank_go;
  logic [N_BANKS-1:0][NUM_RD-1:0][DATA_W-1:0] bank_q;
  logic [NUM_RD-1:0][BANK_W-1:0]         sel_q;
  logic [NUM_RD-1:0]                     valid_q;
  logic [NUM_RD-1:0]                     blocked_q;
  logic [NUM_RD-1:0][DATA_W-1:0]         port_data;

  assign wr_act       = wr_en && (wr_half != 2'b00);
  assign port_en      = {rd1_en, rd0_en};
  assign port_addr[0] = rd0_addr;
  assign port_addr[1] = rd1_addr;

  tpba_decode #(
    .N_BANKS    (N_BANKS),
    .BANK_DEPTH (BANK_DEPTH)
  ) u_decode (
    .rd_addr    (port_addr),
    .wr_act     (wr_act),
    .wr_addr    (wr_addr),
    .rd_bank    (port_bank),
    .rd_row     (port_row),
    .rd_bank_oh (port_bank_oh),
    .wr_bank_oh (wr_bank_oh),
    .wr_pair    (wr_pair)
  );

  tpba_collide #(
    .N_BANKS (N_BANKS)
  ) u_collide (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (port_en),
    .rd_bank_oh (port_bank_oh),
    .wr_bank_oh (wr_bank_oh),
    .rd_block   (port_block),
    .rd_go      (port_go)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    for (genvar p = 0; p < NUM_RD; p++) begin : g_go
      assign bank_go[b][p] = port_go[p] && port_bank_oh[p][b];
    end

    tpba_bank #(
      .DATA_W     (DATA_W),
      .BANK_DEPTH (BANK_DEPTH)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_we   (wr_half & {WR_WORDS{wr_bank_oh[b]}}),
      .wr_pair (wr_pair),
      .wr_data (wr_data),
      .rd_go   (bank_go[b]),
      .rd_row  (port_row),
      .rd_q    (bank_q[b])
    );
  end

  // Per-port status registers and output bank select.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[p]   <= 1'b0;
        blocked_q[p] <= 1'b0;
      end else begin
        valid_q[p]   <= port_go[p];
        blocked_q[p] <= port_block[p];
      end
    end

    always_ff @(posedge clk) begin
      if (port_go[p]) sel_q[p] <= port_bank[p];
    end

    assign port_data[p] = bank_q[sel_q[p]][p];

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(valid_q[p] && blocked_q[p])); // R5

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !valid_q[p] |-> $stable(port_data[p])); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !port_en[p] |=> (!valid_q[p] && !blocked_q[p])); // R9

    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!valid_q[p] && !blocked_q[p])); // R8
  end

  AST_BLOCK_CAUSE0: assert property (@(posedge clk) disable iff (rst)
    (rd0_en && wr_en && (wr_half != 2'b00) &&
     rd0_addr[RD_AW-1 -: BANK_W] == wr_addr[RD_AW-2 -: BANK_W]) |=> rd0_blocked); // R5

  AST_NO_FALSE_BLOCK1: assert property (@(posedge clk) disable iff (rst)
    (rd1_en && (!wr_en || wr_half == 2'b00)) |=> rd1_valid); // R6

  assign rd0_data    = port_data[0];
  assign rd0_valid   = valid_q[0];
  assign rd0_blocked = blocked_q[0];
  assign rd1_data    = port_data[1];
  assign rd1_valid   = valid_q[1];
  assign rd1_blocked = blocked_q[1];
endmodule

// File: tb/tri_port_bank_array_test.sv
module tri_port_bank_array_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd0_en = 1'b0, rd1_en = 1'b0;
  logic [7:0]  rd0_addr = '0, rd1_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_half = '0;
  logic [6:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [31:0] rd0_data, rd1_data;
  logic        rd0_valid, rd0_blocked, rd1_valid, rd1_blocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tri_port_bank_array uut (
    .clk(clk), .rst(rst),
    .rd0_en(rd0_en), .rd0_addr(rd0_addr),
    .rd1_en(rd1_en), .rd1_addr(rd1_addr),
    .wr_en(wr_en), .wr_half(wr_half), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_data(rd0_data), .rd0_valid(rd0_valid), .rd0_blocked(rd0_blocked),
    .rd1_data(rd1_data), .rd1_valid(rd1_valid), .rd1_blocked(rd1_blocked)
  );

  typedef struct {
    logic        v0, b0, k0, v1, b1, k1;
    logic [31:0] d0, d1;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] mdl [256];
  logic [31:0] last0, last1;
  logic        known0 = 1'b0, known1 = 1'b0;

  function automatic logic [31:0] pat(int i);
    logic [7:0] x;
    x = 8'(i);
    return {x ^ 8'h5A, ~x, x, 8'hC3};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(logic e0, logic [7:0] a0, logic e1, logic [7:0] a1,
                       logic we, logic [1:0] hf, logic [6:0] wa,
                       logic [63:0] wd, string tag);
    exp_t e;
    logic act;
    @(negedge clk);
    rd0_en = e0; rd0_addr = a0; rd1_en = e1; rd1_addr = a1;
    wr_en = we; wr_half = hf; wr_addr = wa; wr_data = wd;
    act  = we && (hf != 2'b00);
    e.tag = tag;
    e.b0 = e0 && act && (a0[7:4] == wa[6:3]);
    e.v0 = e0 && !e.b0;
    e.b1 = e1 && act && (a1[7:4] == wa[6:3]);
    e.v1 = e1 && !e.b1;
    if (e.v0) begin last0 = mdl[a0]; known0 = 1'b1; end
    if (e.v1) begin last1 = mdl[a1]; known1 = 1'b1; end
    e.d0 = last0; e.k0 = known0;
    e.d1 = last1; e.k1 = known1;
    if (we && hf[0]) mdl[{wa, 1'b0}] = wd[31:0];
    if (we && hf[1]) mdl[{wa, 1'b1}] = wd[63:32];
    sb.push_back(e);
  endtask

  task automatic idle_cycle();
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 2'b00, 7'h00, 64'h0, "R9");
  endtask

  // Monitor: compares each result in the cycle after its request.
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, "p0 valid",   32'(rd0_valid),   32'(e.v0));
      chk(e.tag, "p0 blocked", 32'(rd0_blocked), 32'(e.b0));
      chk(e.tag, "p1 valid",   32'(rd1_valid),   32'(e.v1));
      chk(e.tag, "p1 blocked", 32'(rd1_blocked), 32'(e.b1));
      if (e.k0) chk(e.tag, "p0 data", rd0_data, e.d0);
      if (e.k1) chk(e.tag, "p1 data", rd1_data, e.d1);
    end
  end

  task automatic check_reset_flags();
    chk("R8", "p0 valid",   32'(rd0_valid),   0);
    chk("R8", "p0 blocked", 32'(rd0_blocked), 0);
    chk("R8", "p1 valid",   32'(rd1_valid),   0);
    chk("R8", "p1 blocked", 32'(rd1_blocked), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd0_en = 1'b1; rd1_en = 1'b1; wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_reset_flags();
    rst = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_flags();
    rst = 1'b0;

    // R3: fill every word through full-pair writes
    for (int p = 0; p < 128; p++)
      drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 2'b11, 7'(p),
            {pat(2*p+1), pat(2*p)}, "R3");

    // R1 R2: sweep every word on both ports, opposite orders
    for (int i = 0; i < 256; i++)
      drive(1'b1, 8'(i), 1'b1, 8'(255-i), 1'b0, 2'b00, 7'h00, 64'h0, "R1");

    // R2: same word, then same bank different rows
    drive(1'b1, 8'h37, 1'b1, 8'h37, 1'b0, 2'b00, 7'h00, 64'h0, "R2");
    drive(1'b1, 8'h52, 1'b1, 8'h5D, 1'b0, 2'b00, 7'h00, 64'h0, "R2");

    // R4: even-only then odd-only writes, with read-backs
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 2'b01, 7'h05, {32'h1111_1111, 32'h2222_2222}, "R4");
    drive(1'b1, 8'h0A, 1'b1, 8'h0B, 1'b0, 2'b00, 7'h00, 64'h0, "R4");
    drive(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 2'b10, 7'h06, {32'h3333_3333, 32'h4444_4444}, "R4");
    drive(1'b1, 8'h0C, 1'b1, 8'h0D, 1'b0, 2'b00, 7'h00, 64'h0, "R4");

    // R5: one port collides, the other reads another bank
    drive(1'b1, 8'h31, 1'b1, 8'h42, 1'b1, 2'b11, 7'h18, {32'hAAAA_0031, 32'hAAAA_0030}, "R5");
    // R5: both ports collide in the written bank
    drive(1'b1, 8'h7F, 1'b1, 8'h70, 1'b1, 2'b10, 7'h3B, {32'hBBBB_0077, 32'hBBBB_0076}, "R5");
    drive(1'b1, 8'h30, 1'b1, 8'h31, 1'b0, 2'b00, 7'h00, 64'h0, "R3");
    drive(1'b1, 8'h76, 1'b1, 8'h77, 1'b0, 2'b00, 7'h00, 64'h0, "R4");

    // R6: write with no halves enabled, and disabled write with halves set
    drive(1'b1, 8'h90, 1'b1, 8'h91, 1'b1, 2'b00, 7'h48, {32'hDEAD_0091, 32'hDEAD_0090}, "R6");
    drive(1'b1, 8'hA4, 1'b0, 8'h00, 1'b0, 2'b11, 7'h52, {32'hDEAD_00A5, 32'hDEAD_00A4}, "R6");
    drive(1'b1, 8'hA4, 1'b1, 8'hA5, 1'b0, 2'b00, 7'h00, 64'h0, "R6");
    drive(1'b1, 8'h90, 1'b1, 8'h91, 1'b0, 2'b00, 7'h00, 64'h0, "R6");

    // R9 R7: idle cycle keeps data, then a blocked read keeps data
    idle_cycle();
    drive(1'b1, 8'h20, 1'b0, 8'h00, 1'b1, 2'b01, 7'h10, {32'hCCCC_0021, 32'hCCCC_0020}, "R7");
    drive(1'b1, 8'h20, 1'b1, 8'h21, 1'b0, 2'b00, 7'h00, 64'h0, "R4");

    // R8: reset mid-run; contents survive
    do_reset();
    drive(1'b1, 8'h37, 1'b1, 8'h0A, 1'b0, 2'b00, 7'h00, 64'h0, "R8");
    idle_cycle();
    idle_cycle();

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule